// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside an Ethernet MAC receive path and decides, from the destination address alone, whether the frame now arriving should be kept. The MAC gives a start-of-frame strobe, then the destination address one byte per valid strobe, first byte first. The block also sees the local station address, a 64-bit multicast hash table, a 6-bit hash index computed elsewhere from the destination address, and three configuration bits: accept broadcast, accept multicast and promiscuous.

Three match terms are formed and gated separately. The broadcast term needs an all-ones address and the broadcast enable. The multicast term needs a group address that is not broadcast, the multicast enable and a set bit in the hash table. The individual term needs an individual address that either equals the station address or arrives while promiscuous mode is on. The accept output is the OR of the three terms. A flag for the receive status shows that an accepted frame carried a group (multicast or broadcast) address. The outcome is registered one clock after the sixth address byte and stays put until the next start-of-frame.

Top module: `rx_addr_filter`

## Requirements
- R1: An all-ones destination address is accepted exactly when `cfg_bcast_en` is 1.
- R2: A group address that is not all ones (bit 0 of the first address byte is 1) is accepted exactly when `cfg_mcast_en` is 1 and the selected hash table bit is 1.
- R3: The hash bit is found in two steps: `hash_idx[5:3]` picks table byte r = `hash_table[8*r+7:8*r]` and `hash_idx[2:0]` picks the bit within that byte.
- R4: An individual address (bit 0 of the first byte is 0) is accepted exactly when it equals the station address, byte k of the address being compared with `station_addr[8*k+7:8*k]` (k = 0 for the first byte), or when `cfg_promisc` is 1.
- R5: `cfg_promisc` has no effect on group addresses: a rejected broadcast or multicast frame stays rejected with it set.
- R6: `grp_flag` is 1 exactly when `accept` is 1 and the address is a group address.
- R7: `decision_vld`, `accept` and `grp_flag` change on the clock edge that follows the cycle in which the sixth address byte is taken; the configuration bits, `hash_idx` and the tables are sampled in that cycle and have no effect at any other time.
- R8: A `sof` cycle drives all three outputs to 0 at the next edge, and a byte strobed in the same cycle as `sof` is not taken as an address byte.
- R9: Bytes after the sixth are ignored, and the outcome holds until the next `sof`.
- R10: After reset, `decision_vld`, `accept` and `grp_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame strobe; clears the outcome and the byte count |
| byte_vld | input | 1 | Qualifies `byte_data` |
| byte_data | input | 8 | Destination address byte, first byte first |
| station_addr | input | 48 | Local address, byte k in bits 8k+7:8k |
| hash_table | input | 64 | Multicast hash table, eight bytes of eight bits |
| hash_idx | input | 6 | Hash index, valid with the sixth address byte |
| cfg_bcast_en | input | 1 | Accept broadcast |
| cfg_mcast_en | input | 1 | Accept multicast on hash hit |
| cfg_promisc | input | 1 | Accept every individual address |
| decision_vld | output | 1 | Outcome is valid for the current frame |
| accept | output | 1 | Frame is to be kept |
| grp_flag | output | 1 | Accepted frame had a group address |

## Verification
The bench aims at the gating corners where the three terms interact: a broadcast or a hash-missing multicast while promiscuous mode is on, which a design that applied promiscuous mode to every frame would wrongly accept. The hash is probed with single-bit tables at indices 0, 7, 56 and 63, where a swapped register and bit split or a reversed byte order selects the wrong bit. A byte strobed in the `sof` cycle and trailing bytes after the sixth catch a collector that shifts or overwrites the stored address. Configuration and index values that change outside the sixth-byte cycle catch a design that samples them late or keeps its outcome transparent.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  // One bit per separately gated match term.
  typedef struct packed {
    logic bc;  // broadcast term
    logic mc;  // multicast term
    logic ph;  // individual / promiscuous term
  } match_terms_t;

endpackage

// File: rtl/rxaf_da_collect.sv
module rxaf_da_collect #(
  parameter int N_BYTES = 6,
  parameter int BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sof,
  input  logic                      byte_vld,
  input  logic [BYTE_W-1:0]         byte_data,
  output logic                      last_byte,
  output logic [N_BYTES*BYTE_W-1:0] da_word
);

  localparam int CNT_W = $clog2(N_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(N_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             take;

  assign take      = byte_vld && !sof && (cnt_q != CNT_DONE);
  assign last_byte = take && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_en = sof || take;
    if (sof) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Earlier bytes are stored; the final byte is used straight from the input.
  for (genvar k = 0; k < N_BYTES - 1; k++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    logic              byte_en;
    assign byte_en = take && (cnt_q == CNT_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_en) byte_q <= byte_data;
    end
    assign da_word[k*BYTE_W +: BYTE_W] = byte_q;
  end
  assign da_word[(N_BYTES-1)*BYTE_W +: BYTE_W] = byte_data;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_DONE); // R9
  AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> !last_byte); // R9

endmodule

// File: rtl/rxaf_hash_sel.sv
module rxaf_hash_sel #(
  parameter int REGS   = 8,
  parameter int BYTE_W = 8
) (
  input  logic [REGS*BYTE_W-1:0]                         table_bits,
  input  logic [$clog2(REGS)+$clog2(BYTE_W)-1:0]         idx,
  output logic                                           hit
);

  localparam int BIT_SEL_W = $clog2(BYTE_W);
  localparam int REG_SEL_W = $clog2(REGS);

  logic [BIT_SEL_W-1:0] bit_sel;
  logic [REG_SEL_W-1:0] reg_sel;
  logic [REGS-1:0]      row_bit;

  assign bit_sel = idx[BIT_SEL_W-1:0];
  assign reg_sel = idx[BIT_SEL_W +: REG_SEL_W];

  // First level: the same bit is picked out of every table byte.
  for (genvar r = 0; r < REGS; r++) begin : g_row
    logic [BYTE_W-1:0] row;
    assign row        = table_bits[r*BYTE_W +: BYTE_W];
    assign row_bit[r] = row[bit_sel];
  end

  // Second level: the register index picks one of those bits.
  assign hit = row_bit[reg_sel];

endmodule

// File: rtl/rxaf_classify.sv
module rxaf_classify
  import rxaf_pkg::*;
#(
  parameter int N_BYTES = 6,
  parameter int BYTE_W  = 8
) (
  input  logic [N_BYTES*BYTE_W-1:0] da_word,
  input  logic [N_BYTES*BYTE_W-1:0] station,
  input  logic                      hash_hit,
  input  logic                      cfg_bcast_en,
  input  logic                      cfg_mcast_en,
  input  logic                      cfg_promisc,
  output logic                      is_group,
  output logic                      is_bcast,
  output match_terms_t              terms
);

  logic [N_BYTES-1:0] byte_eq;
  logic [N_BYTES-1:0] byte_ones;
  logic               station_hit;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_cmp
    assign byte_eq[k]   = (da_word[k*BYTE_W +: BYTE_W] == station[k*BYTE_W +: BYTE_W]);
    assign byte_ones[k] = &da_word[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    is_group    = da_word[0];
    is_bcast    = &byte_ones;
    station_hit = &byte_eq;
    terms.bc    = is_bcast && cfg_bcast_en;
    terms.mc    = is_group && !is_bcast && cfg_mcast_en && hash_hit;
    terms.ph    = !is_group && (station_hit || cfg_promisc);
  end

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sof,
  input  logic         last_byte,
  input  logic         is_group,
  input  match_terms_t terms,
  output logic         decision_vld,
  output logic         accept,
  output logic         grp_flag
);

  logic vld_q, vld_d;
  logic acc_q, acc_d;
  logic grp_q, grp_d;
  logic upd_en;

  always_comb begin
    upd_en = sof || last_byte;
    if (sof) begin
      vld_d = 1'b0;
      acc_d = 1'b0;
      grp_d = 1'b0;
    end else begin
      vld_d = 1'b1;
      acc_d = terms.bc || terms.mc || terms.ph;
      grp_d = acc_d && is_group;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      grp_q <= 1'b0;
    end else if (upd_en) begin
      vld_q <= vld_d;
      acc_q <= acc_d;
      grp_q <= grp_d;
    end
  end

  assign decision_vld = vld_q;
  assign accept       = acc_q;
  assign grp_flag     = grp_q;

  AST_VLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !sof) |=> decision_vld); // R7
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (!decision_vld && !accept && !grp_flag)); // R8
  AST_HOLD_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !last_byte) |=> ($stable(accept) && $stable(grp_flag) && $stable(decision_vld))); // R9
  AST_GRP_NEEDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    grp_flag |-> (accept && decision_vld)); // R6

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  parameter int HASH_REGS  = 8,
  localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
  localparam int TABLE_W   = HASH_REGS * BYTE_W,
  localparam int IDX_W     = $clog2(HASH_REGS) + $clog2(BYTE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof,
  input  logic               byte_vld,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic [ADDR_W-1:0]  station_addr,
  input  logic [TABLE_W-1:0] hash_table,
  input  logic [IDX_W-1:0]   hash_idx,
  input  logic               cfg_bcast_en,
  input  logic               cfg_mcast_en,
  input  logic               cfg_promisc,
  output logic               decision_vld,
  output logic               accept,
  output logic               grp_flag
);

  logic              last_byte;
  logic [ADDR_W-1:0] da_word;
  logic              hash_hit;
  logic              is_group;
  logic              is_bcast;
  match_terms_t      terms;

  rxaf_da_collect #(.N_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .last_byte (last_byte),
    .da_word   (da_word)
  );

  rxaf_hash_sel #(.REGS(HASH_REGS), .BYTE_W(BYTE_W)) u_hash (
    .table_bits (hash_table),
    .idx        (hash_idx),
    .hit        (hash_hit)
  );

  rxaf_classify #(.N_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_classify (
    .da_word      (da_word),
    .station      (station_addr),
    .hash_hit     (hash_hit),
    .cfg_bcast_en (cfg_bcast_en),
    .cfg_mcast_en (cfg_mcast_en),
    .cfg_promisc  (cfg_promisc),
    .is_group     (is_group),
    .is_bcast     (is_bcast),
    .terms        (terms)
  );

  rxaf_decide u_decide (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (sof),
    .last_byte    (last_byte),
    .is_group     (is_group),
    .terms        (terms),
    .decision_vld (decision_vld),
    .accept       (accept),
    .grp_flag     (grp_flag)
  );

  AST_BCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && is_bcast && !cfg_bcast_en) |=> !accept); // R1
  AST_MCAST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && is_group && !is_bcast && !hash_hit) |=> !accept); // R2
  AST_PROMISC_UNI: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !is_group && cfg_promisc) |=> accept); // R4
  AST_BCAST_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    is_bcast |-> is_group); // R5

endmodule

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/100ps
module tb_rx_addr_filter;

  logic        clk;
  logic        rst_n;
  logic        sof;
  logic        byte_vld;
  logic [7:0]  byte_data;
  logic [47:0] station_addr;
  logic [63:0] hash_table;
  logic [5:0]  hash_idx;
  logic        cfg_bcast_en, cfg_mcast_en, cfg_promisc;
  logic        decision_vld, accept, grp_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_data(byte_data),
    .station_addr(station_addr), .hash_table(hash_table), .hash_idx(hash_idx),
    .cfg_bcast_en(cfg_bcast_en), .cfg_mcast_en(cfg_mcast_en), .cfg_promisc(cfg_promisc),
    .decision_vld(decision_vld), .accept(accept), .grp_flag(grp_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Expected {grp_flag, accept} from the requirements.
  function automatic logic [1:0] model(input logic [47:0] da, input logic [47:0] sta,
                                       input logic [63:0] tbl, input logic [5:0] idx,
                                       input logic bc, input logic mc, input logic pr);
    logic grp, acc, hbit;
    grp  = da[0];
    hbit = tbl[8*idx[5:3] + idx[2:0]];  // R3 register/bit split
    if (&da)      acc = bc;                   // R1
    else if (grp) acc = mc && hbit;           // R2
    else          acc = (da == sta) || pr;    // R4
    return {grp && acc, acc};                 // R6
  endfunction

  task automatic put_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    byte_vld  = 1'b1;
    byte_data = b;
    @(negedge clk);
    byte_vld  = 1'b0;
    byte_data = 8'($urandom);
    repeat (gap) @(negedge clk);
  endtask

  task automatic run_frame(input logic [47:0] da, input logic [63:0] tbl, input logic [5:0] idx,
                           input logic bc, input logic mc, input logic pr, input int gapmax);
    logic [1:0] exp;
    exp = model(da, station_addr, tbl, idx, bc, mc, pr);
    hash_table = tbl;
    @(negedge clk);
    sof       = 1'b1;
    byte_vld  = 1'b1;              // R8: must not be taken as a byte
    byte_data = 8'($urandom);
    @(negedge clk);
    sof      = 1'b0;
    byte_vld = 1'b0;
    check("R8 cleared after sof", {5'd0, decision_vld, accept, grp_flag}, 8'd0);
    for (int k = 0; k < 6; k++) begin
      if (k == 5) begin
        hash_idx = idx; cfg_bcast_en = bc; cfg_mcast_en = mc; cfg_promisc = pr;
      end else begin
        hash_idx = 6'($urandom); {cfg_bcast_en, cfg_mcast_en, cfg_promisc} = 3'($urandom);
      end
      @(negedge clk);
      byte_vld  = 1'b1;
      byte_data = da[8*k +: 8];
      @(negedge clk);
      byte_vld  = 1'b0;
      hash_idx  = 6'($urandom);
      {cfg_bcast_en, cfg_mcast_en, cfg_promisc} = 3'($urandom);
      if (k == 5) begin
        check("R7 valid after sixth byte", {7'd0, decision_vld}, 8'd1);
        check("R1/R2/R4 accept", {7'd0, accept}, {7'd0, exp[0]});
        check("R6 grp_flag", {7'd0, grp_flag}, {7'd0, exp[1]});
      end else begin
        check("R7 not valid early", {7'd0, decision_vld}, 8'd0);
        repeat ($urandom % (gapmax + 1)) @(negedge clk);
      end
    end
    put_byte(8'($urandom), 0);
    put_byte(8'($urandom), 1);
    check("R9 hold after extra bytes",
          {5'd0, decision_vld, accept, grp_flag}, {5'd0, 1'b1, exp[0], exp[1]});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] da;
    void'($urandom(32'd1357));
    rst_n = 1'b0; sof = 1'b0; byte_vld = 1'b0; byte_data = '0;
    station_addr = 48'h5A_3C_19_77_C2_00; hash_table = '0; hash_idx = '0;
    cfg_bcast_en = 1'b0; cfg_mcast_en = 1'b0; cfg_promisc = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {5'd0, decision_vld, accept, grp_flag}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", {5'd0, decision_vld, accept, grp_flag}, 8'd0);

    // R1 / R5: broadcast gating, promiscuous has no effect
    run_frame(48'hFFFF_FFFF_FFFF, 64'h0, 6'd0, 1'b1, 1'b0, 1'b0, 0);
    run_frame(48'hFFFF_FFFF_FFFF, '1,    6'd9, 1'b0, 1'b1, 1'b1, 0);  // R5
    // R2 / R5: multicast miss stays rejected with promisc on
    run_frame(48'h11_22_33_44_55_01, 64'h0, 6'd20, 1'b1, 1'b1, 1'b1, 1); // R5
    run_frame(48'h11_22_33_44_55_01, '1,   6'd20, 1'b0, 1'b0, 1'b1, 1);   // R2 disabled
    // R3: single-bit tables at extreme indices
    run_frame(48'h00_00_00_00_00_03, 64'h1,                 6'd0,  1'b0, 1'b1, 1'b0, 0);
    run_frame(48'h00_00_00_00_00_03, 64'h80,                6'd7,  1'b0, 1'b1, 1'b0, 0);
    run_frame(48'h00_00_00_00_00_03, 64'h0100_0000_0000_0000, 6'd56, 1'b0, 1'b1, 1'b0, 0);
    run_frame(48'h00_00_00_00_00_03, 64'h8000_0000_0000_0000, 6'd63, 1'b0, 1'b1, 1'b0, 0);
    run_frame(48'h00_00_00_00_00_03, 64'h8000_0000_0000_0000, 6'd7,  1'b0, 1'b1, 1'b0, 0);
    // R4: station match, mismatch in last byte, promiscuous
    run_frame(station_addr, 64'h0, 6'd0, 1'b0, 1'b0, 1'b0, 2);
    run_frame(station_addr ^ 48'h8000_0000_0000, 64'h0, 6'd0, 1'b1, 1'b1, 1'b0, 2);
    run_frame(station_addr ^ 48'h8000_0000_0000, 64'h0, 6'd0, 1'b0, 1'b0, 1'b1, 2);

    for (int f = 0; f < 250; f++) begin
      case ($urandom % 5)
        0: da = 48'hFFFF_FFFF_FFFF;
        1: da = station_addr;
        2: da = station_addr ^ (48'h2 << (8 * ($urandom % 6)));
        3: begin da = {16'($urandom), 32'($urandom)}; da[0] = 1'b1; if (&da) da[47] = 1'b0; end
        default: begin da = {16'($urandom), 32'($urandom)}; da[0] = 1'b0; end
      endcase
      run_frame(da, {32'($urandom), 32'($urandom)}, 6'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 2);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule